// File: doc/BRIEF.md
# Replay Packet-Number Guard

This block protects one receive session against replayed frames. Each frame arrives with a packet number (PN), and the block accepts the frame only if its PN is strictly larger than the last accepted PN of the session. It can also require accepted PNs to be even or odd. The number of PN bits that count is chosen per session: 24, 48 or 128. The block keeps the last accepted PN in a 128-bit register, together with a flag that marks that register as valid.

A session can start in two ways. Software may preload the stored PN and set its valid flag. If software does not, the first checked frame seeds the register and is not judged. When error handling is enabled, a failed check raises a sticky error flag. While that flag is set, every later frame is passed to a bypass (exception) path without any check, until software clears the flag.

Each frame strobe gives one verdict on the following clock cycle: accept, reject or bypass.

Top module: `pn_replay_guard`

## Requirements
- R1: A frame strobed in cycle N gives, in cycle N+1, a result strobe with exactly one of accept, reject or bypass. Without a frame strobe, the result strobe and all three verdicts stay low.
- R2: If the check enable is low and the error flag is clear, the frame is accepted. The stored PN and its valid flag do not change, and the parity controls have no effect.
- R3: If the check enable is high, the width code is legal and the valid flag is clear, the frame is accepted without comparison or parity test. The stored PN takes the frame PN truncated to the selected width, and the valid flag is set.
- R4: Width code 0 selects the low 24 PN bits, code 1 the low 48 bits and code 2 all 128 bits. Bits above the selected width are ignored, both in the received PN and in the stored PN, and they are stored as zero.
- R5: With a valid stored PN, a frame whose truncated PN is equal to or less than the truncated stored PN is rejected. The stored PN changes only on accepting a checked frame or on a software load.
- R6: If the stored PN holds the all-ones value of the selected width, every later checked frame is rejected. This includes frames whose full PN only exceeds the stored value through bits above the selected width.
- R7: Parity is tested on PN bit 0. With the even-only control set, a PN with bit 0 = 1 is rejected. With the odd-only control set, a PN with bit 0 = 0 is rejected.
- R8: Width code 3 is illegal. Every checked frame is rejected under it, including a frame that would otherwise seed the register, and the valid flag stays as it was.
- R9: A rejected frame sets the sticky error flag one cycle after its strobe, but only if error handling was enabled at the strobe. With error handling disabled, a rejection leaves the flag clear.
- R10: While the error flag is set, every frame gets the bypass verdict, whatever the check enable is. The stored PN and both flags are left unchanged.
- R11: A software clear pulse clears the error flag on the next cycle and leaves the stored PN unchanged. It takes priority over a rejection that sets the flag in the same cycle.
- R12: A software load pulse writes the given PN and valid bit into the stored state. It takes priority over a frame update in the same cycle, while that frame still gets its verdict against the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | Frame strobe |
| frm_pn | input | 128 | Received packet number |
| cfg_check_en | input | 1 | Enable the PN check |
| cfg_width | input | 2 | Width code: 0 = 24, 1 = 48, 2 = 128 bits, 3 = illegal |
| cfg_even_only | input | 1 | Accepted PNs must be even |
| cfg_odd_only | input | 1 | Accepted PNs must be odd |
| cfg_err_handle_en | input | 1 | A rejection raises the sticky error flag |
| sw_load | input | 1 | Software preload strobe |
| sw_load_pn | input | 128 | PN value to preload |
| sw_load_valid | input | 1 | Valid bit to preload |
| sw_clr_err | input | 1 | Software clear of the error flag |
| res_valid | output | 1 | Verdict strobe |
| res_accept | output | 1 | Frame accepted |
| res_reject | output | 1 | Frame rejected |
| res_bypass | output | 1 | Frame sent to bypass path |
| pn_valid | output | 1 | Stored PN is valid |
| pn_err | output | 1 | Sticky error flag |
| last_pn | output | 128 | Stored PN |

## Verification
Suppose the stored PN or its valid flag is wrong. The port `last_pn` shows it one cycle after the frame that caused it, and the verdict of the next frame differs from the one expected. A wrong error flag shows up right away at `pn_err`, and from then on each frame reports bypass instead of a verdict.

The boundary cases that matter most are:
- equal PNs;
- the all-ones value of the narrow widths;
- bits above the selected width;
- a clear or a load that arrives in the same cycle as a frame.

// File: rtl/pn_guard_pkg.sv
package pn_guard_pkg;

    localparam int PN_BITS  = 128;
    localparam int NARROW_W = 24;
    localparam int MID_W    = 48;

    typedef enum logic [1:0] {
        PNW_NARROW = 2'd0,
        PNW_MID    = 2'd1,
        PNW_FULL   = 2'd2,
        PNW_BAD    = 2'd3
    } pn_width_e;

    typedef struct packed {
        logic [PN_BITS-1:0] pn;
        logic               valid;
        logic               err;
        logic               res_vld;
        logic               res_acc;
        logic               res_rej;
        logic               res_byp;
    } guard_state_t;

endpackage

// File: rtl/pn_width_mask.sv
module pn_width_mask
    import pn_guard_pkg::*;
#(
    parameter int PN_W = PN_BITS
) (
    input  logic [1:0]      width,
    input  logic [PN_W-1:0] rx_pn,
    input  logic [PN_W-1:0] st_pn,
    output logic [PN_W-1:0] rx_m,
    output logic [PN_W-1:0] st_m,
    output logic            legal
);

    pn_width_e wsel;
    assign wsel  = pn_width_e'(width);
    assign legal = (wsel != PNW_BAD);

    // Each bit lane decides on its own whether it lies inside the selected width.
    for (genvar i = 0; i < PN_W; i++) begin : g_lane
        localparam bit IN_NARROW = (i < NARROW_W);
        localparam bit IN_MID    = (i < MID_W);
        logic keep;
        always_comb begin
            case (wsel)
                PNW_NARROW: keep = IN_NARROW;
                PNW_MID:    keep = IN_MID;
                PNW_FULL:   keep = 1'b1;
                default:    keep = 1'b0;
            endcase
        end
        assign rx_m[i] = rx_pn[i] & keep;
        assign st_m[i] = st_pn[i] & keep;
    end

endmodule

// File: rtl/pn_order_check.sv
module pn_order_check #(
    parameter int PN_W  = 128,
    parameter int SEG_W = 16
) (
    input  logic [PN_W-1:0] rx_m,
    input  logic [PN_W-1:0] st_m,
    input  logic            even_only,
    input  logic            odd_only,
    output logic            pass
);

    localparam int NSEG = PN_W / SEG_W;

    logic [NSEG-1:0] seg_gt;
    logic [NSEG-1:0] seg_eq;

    // Segment-wise compare, then a ripple from least to most significant segment.
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic [SEG_W-1:0] a;
        logic [SEG_W-1:0] b;
        assign a         = rx_m[s*SEG_W +: SEG_W];
        assign b         = st_m[s*SEG_W +: SEG_W];
        assign seg_gt[s] = (a > b);
        assign seg_eq[s] = (a == b);
    end

    logic greater;
    always_comb begin
        greater = 1'b0;
        for (int s = 0; s < NSEG; s++) begin
            greater = seg_gt[s] | (seg_eq[s] & greater);
        end
    end

    logic parity_ok;
    assign parity_ok = !(even_only && rx_m[0]) && !(odd_only && !rx_m[0]);
    assign pass      = greater && parity_ok;

endmodule

// File: rtl/pn_replay_guard.sv
module pn_replay_guard
    import pn_guard_pkg::*;
#(
    parameter int PN_W  = PN_BITS,
    parameter int SEG_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frm_valid,
    input  logic [PN_W-1:0] frm_pn,
    input  logic            cfg_check_en,
    input  logic [1:0]      cfg_width,
    input  logic            cfg_even_only,
    input  logic            cfg_odd_only,
    input  logic            cfg_err_handle_en,
    input  logic            sw_load,
    input  logic [PN_W-1:0] sw_load_pn,
    input  logic            sw_load_valid,
    input  logic            sw_clr_err,
    output logic            res_valid,
    output logic            res_accept,
    output logic            res_reject,
    output logic            res_bypass,
    output logic            pn_valid,
    output logic            pn_err,
    output logic [PN_W-1:0] last_pn
);

    guard_state_t st_q, st_d;

    logic [PN_W-1:0] rx_m;
    logic [PN_W-1:0] st_m;
    logic            width_ok;
    logic            order_ok;

    pn_width_mask #(.PN_W(PN_W)) u_mask (
        .width (cfg_width),
        .rx_pn (frm_pn),
        .st_pn (st_q.pn),
        .rx_m  (rx_m),
        .st_m  (st_m),
        .legal (width_ok)
    );

    pn_order_check #(.PN_W(PN_W), .SEG_W(SEG_W)) u_order (
        .rx_m      (rx_m),
        .st_m      (st_m),
        .even_only (cfg_even_only),
        .odd_only  (cfg_odd_only),
        .pass      (order_ok)
    );

    always_comb begin
        logic fail;
        st_d         = st_q;
        st_d.res_vld = frm_valid;
        st_d.res_acc = 1'b0;
        st_d.res_rej = 1'b0;
        st_d.res_byp = 1'b0;
        fail         = 1'b0;

        if (frm_valid) begin
            if (st_q.err) begin
                st_d.res_byp = 1'b1;
            end else if (!cfg_check_en) begin
                st_d.res_acc = 1'b1;
            end else if (!width_ok) begin
                fail = 1'b1;
            end else if (!st_q.valid) begin
                st_d.res_acc = 1'b1;
                st_d.pn      = rx_m;
                st_d.valid   = 1'b1;
            end else if (order_ok) begin
                st_d.res_acc = 1'b1;
                st_d.pn      = rx_m;
            end else begin
                fail = 1'b1;
            end
        end

        if (fail) begin
            st_d.res_rej = 1'b1;
            if (cfg_err_handle_en) st_d.err = 1'b1;
        end

        if (sw_load) begin
            st_d.pn    = sw_load_pn;
            st_d.valid = sw_load_valid;
        end

        if (sw_clr_err) st_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid  = st_q.res_vld;
    assign res_accept = st_q.res_acc;
    assign res_reject = st_q.res_rej;
    assign res_bypass = st_q.res_byp;
    assign pn_valid   = st_q.valid;
    assign pn_err     = st_q.err;
    assign last_pn    = st_q.pn;

endmodule

// File: rtl/pn_replay_guard_chk.sv
module pn_replay_guard_chk #(
    parameter int PN_W = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frm_valid,
    input logic            cfg_check_en,
    input logic            sw_load,
    input logic            sw_clr_err,
    input logic            res_valid,
    input logic            res_accept,
    input logic            res_reject,
    input logic            res_bypass,
    input logic            pn_err,
    input logic [PN_W-1:0] last_pn
);

    a_r1_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones({res_accept, res_reject, res_bypass}) == 1));

    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ({res_accept, res_reject, res_bypass} == 3'b000));

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> res_valid);

    a_r2_disabled_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !cfg_check_en && !pn_err) |=> res_accept);

    a_r5_hold_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !sw_load) |=> ((res_reject || res_bypass) -> $stable(last_pn)));

    a_r9_rise_from_reject: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pn_err) |-> res_reject);

    a_r10_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && pn_err) |=> res_bypass);

    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pn_err && !sw_clr_err) |=> pn_err);

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr_err |=> !pn_err);

endmodule

bind pn_replay_guard pn_replay_guard_chk #(.PN_W(PN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_valid    (frm_valid),
    .cfg_check_en (cfg_check_en),
    .sw_load      (sw_load),
    .sw_clr_err   (sw_clr_err),
    .res_valid    (res_valid),
    .res_accept   (res_accept),
    .res_reject   (res_reject),
    .res_bypass   (res_bypass),
    .pn_err       (pn_err),
    .last_pn      (last_pn)
);

// File: tb/tb_pn_replay_guard.sv
`timescale 1ns/1ps
module tb_pn_replay_guard;

    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frm_valid = 1'b0;
    logic [W-1:0] frm_pn = '0;
    logic         cfg_check_en = 1'b0;
    logic [1:0]   cfg_width = 2'd2;
    logic         cfg_even_only = 1'b0;
    logic         cfg_odd_only = 1'b0;
    logic         cfg_err_handle_en = 1'b0;
    logic         sw_load = 1'b0;
    logic [W-1:0] sw_load_pn = '0;
    logic         sw_load_valid = 1'b0;
    logic         sw_clr_err = 1'b0;
    logic         res_valid, res_accept, res_reject, res_bypass, pn_valid, pn_err;
    logic [W-1:0] last_pn;

    always #2.5 clk = ~clk;

    pn_replay_guard dut (.*);

    typedef struct {
        int           kind;   // 0 accept, 1 reject, 2 bypass
        logic [W-1:0] pn;
        logic         valid;
        logic         err;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    logic [W-1:0] m_pn = '0;
    logic         m_valid = 1'b0;
    logic         m_err = 1'b0;

    function automatic logic [W-1:0] wmask(logic [1:0] w);
        case (w)
            2'd0: return {{(W-24){1'b0}}, {24{1'b1}}};
            2'd1: return {{(W-48){1'b0}}, {48{1'b1}}};
            2'd2: return {W{1'b1}};
            default: return '0;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one frame with optional same-cycle software actions.
    task automatic send(logic [W-1:0] pn, string tag, bit clr = 0, bit ld = 0,
                        logic [W-1:0] ldpn = '0, bit ldv = 0);
        exp_t e;
        logic [W-1:0] mk;
        bit pass;
        mk = wmask(cfg_width);
        @(negedge clk);
        frm_valid = 1'b1; frm_pn = pn;
        sw_clr_err = clr; sw_load = ld; sw_load_pn = ldpn; sw_load_valid = ldv;
        if (m_err) e.kind = 2;
        else if (!cfg_check_en) e.kind = 0;
        else if (cfg_width == 2'd3) e.kind = 1;
        else if (!m_valid) begin
            e.kind = 0; m_pn = pn & mk; m_valid = 1'b1;
        end else begin
            pass = ((pn & mk) > (m_pn & mk))
                   && !(cfg_even_only && pn[0]) && !(cfg_odd_only && !pn[0]);
            if (pass) begin e.kind = 0; m_pn = pn & mk; end
            else e.kind = 1;
        end
        if (e.kind == 1 && cfg_err_handle_en) m_err = 1'b1;
        if (ld) begin m_pn = ldpn; m_valid = ldv; end
        if (clr) m_err = 1'b0;
        e.pn = m_pn; e.valid = m_valid; e.err = m_err; e.tag = tag;
        @(posedge clk);
        #1 q.push_back(e);
        @(negedge clk);
        frm_valid = 1'b0; sw_clr_err = 1'b0; sw_load = 1'b0;
    endtask

    task automatic sw_op(bit clr, bit ld, logic [W-1:0] ldpn, bit ldv, string tag);
        @(negedge clk);
        sw_clr_err = clr; sw_load = ld; sw_load_pn = ldpn; sw_load_valid = ldv;
        if (ld) begin m_pn = ldpn; m_valid = ldv; end
        if (clr) m_err = 1'b0;
        @(negedge clk);
        sw_clr_err = 1'b0; sw_load = 1'b0;
        chk(pn_err == m_err, {tag, " err flag"}, W'(pn_err), W'(m_err));
        chk(last_pn == m_pn, {tag, " stored pn"}, last_pn, m_pn);
        chk(pn_valid == m_valid, {tag, " valid flag"}, W'(pn_valid), W'(m_valid));
    endtask

    // Monitor: compares every verdict against the scoreboard queue (R1 timing).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (res_valid) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R1 unexpected verdict", W'(1), W'(0));
                    end else begin
                        exp_t e;
                        int   k;
                        e = q.pop_front();
                        k = res_accept ? 0 : res_reject ? 1 : res_bypass ? 2 : 3;
                        chk(k == e.kind && $countones({res_accept, res_reject, res_bypass}) == 1,
                            {e.tag, " verdict"}, W'(k), W'(e.kind));
                        chk(last_pn == e.pn, {e.tag, " stored pn"}, last_pn, e.pn);
                        chk(pn_valid == e.valid, {e.tag, " valid flag"}, W'(pn_valid), W'(e.valid));
                        chk(pn_err == e.err, {e.tag, " err flag"}, W'(pn_err), W'(e.err));
                    end
                end else if (q.size() != 0) begin
                    void'(q.pop_front());
                    chk(1'b0, "R1 verdict missing one cycle after strobe", W'(0), W'(1));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!res_valid && !pn_valid && !pn_err && last_pn == '0, "reset state",
            {res_valid, pn_valid, pn_err}, '0);

        // R2: check disabled
        cfg_check_en = 0; cfg_even_only = 1;
        send(W'(5), "R2 check disabled accepts");

        // R3 + R4: first frame seeds, truncated to 24 bits, parity ignored
        cfg_check_en = 1; cfg_width = 0;
        send(W'(128'hAB000003), "R3 R4 first frame seeds");
        send(W'(3), "R5 equal rejected");
        send(W'(2), "R5 lower rejected");
        send(W'(128'hFF000004), "R4 upper bits ignored");
        send(W'(7), "R7 even-only rejects odd");
        send(W'(8), "R7 even-only accepts even");
        cfg_even_only = 0; cfg_odd_only = 1;
        send(W'(10), "R7 odd-only rejects even");
        send(W'(11), "R7 odd-only accepts odd");
        cfg_odd_only = 0;

        // R6: wrap at the narrow width
        sw_op(0, 1, W'(24'hFFFFFF), 1, "R12 preload");
        send(W'(128'h1000000), "R6 wrap to zero rejected");
        send(W'(128'h2FFFFFF), "R6 all-ones equal rejected");

        // R4: 48-bit width sees the carry bit
        cfg_width = 1;
        send(W'(128'h1000001), "R4 48-bit compare accepts");
        sw_op(0, 1, {80'h0, 48'hFFFF_FFFF_FFFF}, 1, "R12 preload 48");
        send({64'h1, 64'h0}, "R6 48-bit wrap rejected");

        // R8: illegal width
        cfg_width = 3;
        send(W'(128'hFFFF_FFFF_FFFF_FFFF), "R8 illegal width rejects");
        sw_op(0, 1, '0, 0, "R12 clear valid");
        send(W'(9), "R8 illegal width blocks seeding");
        cfg_width = 2;
        send({1'b1, 127'h0}, "R3 full-width seed");

        // R9 / R10 / R11
        cfg_err_handle_en = 1;
        send(W'(1), "R9 reject raises error");
        send({W{1'b1}}, "R10 bypass while error");
        cfg_check_en = 0;
        send(W'(3), "R10 bypass ignores check enable");
        cfg_check_en = 1;
        sw_op(1, 0, '0, 0, "R11 clear keeps pn");
        send(W'(2), "R11 clear wins over same-cycle reject", 1);
        cfg_err_handle_en = 0;
        send(W'(2), "R9 no handling keeps flag clear");

        // R12: load wins over a passing frame in the same cycle
        send({1'b1, 127'h5}, "R12 load beats frame update", 0, 1, W'(77), 1);
        send(W'(78), "R12 later frame compares to loaded");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule